// File: doc/BRIEF.md
# Receive Destination Address Filter with Loadable Match Table

This block decides, for each incoming frame, whether its 48-bit destination address is accepted, and labels accepted frames as multicast or broadcast. It holds a table of sixteen 6-byte station addresses and a 16-bit enable mask. It evaluates the address against three receive-mode bits and the table, in a fixed order of precedence.

The table is filled by a load sequencer. Software starts a load with an entry count and a base pointer. The memory reader then streams 16-bit words into the block. The stream carries four words per entry, followed by a single mask word. While the chip is held in its reset mode, any table entry can be read back through three 16-bit ports.

Top module: `cam_addr_filter`

## Requirements
- R1: After reset, `res_valid`, `accept`, `is_mcast`, `is_bcast`, `load_busy` and `load_done` are 0. All table entries are zero and the enable mask is zero, so even an all-zero address is rejected when no mode bit is set.
- R2: A probe presented with `dst_valid` high is judged at the next clock edge. `res_valid` and the verdict flags are registered and hold for exactly one cycle per probe, and they read 0 in cycles without a probe.
- R3: With `rx_ctrl` bit 12 set, an address whose first byte (`dst_addr[7:0]`) has bit 0 clear is accepted with both class flags low. An address with that bit set is not accepted by this rule.
- R4: With `rx_ctrl` bit 11 set, an address whose first byte has bit 0 set is accepted with `is_mcast`. This check is made before the broadcast check, so the all-ones address gets `is_mcast` and not `is_bcast` while bit 11 is set.
- R5: With `rx_ctrl` bit 13 set and no earlier rule applying, the all-ones address is accepted with `is_bcast`. With bit 13 clear, the all-ones address falls through to the table.
- R6: If no mode rule applies, the address is accepted with no flags only when it equals a table entry whose enable-mask bit is set. A match on a disabled entry, or no match at all, rejects the frame.
- R7: `load_start` while idle, with a non-zero `load_count`, loads that many entries starting at index 0. Each entry takes four words. Word 0 is discarded. Words 1, 2 and 3 supply address bytes (0,1), (2,3) and (4,5), low byte first, so byte k of the entry sits at bits [8k+7:8k] of the compared address.
- R8: `fetch_ptr` equals `load_base` when the load starts and advances by 8 after each completed entry. Once the count is exhausted, the next word becomes the enable mask (bit i enables entry i). In the cycle after that word, `load_busy` is 0 and `load_done` is 1, for one cycle only.
- R9: A `load_start` with `load_count` equal to 0 skips the entries and takes the next word directly as the enable mask.
- R10: Words offered while no load is in progress change neither the table nor the pointer. A `load_start` during a load is ignored: the pointer, the count and the remaining sequence are unchanged.
- R11: While `in_reset` is 1, `rb_lo`, `rb_mid` and `rb_hi` show bytes (1,0), (3,2) and (5,4) of entry `cam_sel`, with the higher-numbered byte in the upper half. While `in_reset` is 0, all three read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_reset | input | 1 | Chip reset mode; enables table readback |
| rx_ctrl | input | 16 | Receive control; bits 11, 12 and 13 select the modes |
| dst_valid | input | 1 | Destination address probe strobe |
| dst_addr | input | 48 | Destination address; first byte in bits [7:0] |
| load_start | input | 1 | Start a table load |
| load_count | input | 5 | Number of entries to load |
| load_base | input | 16 | Byte pointer to the first descriptor |
| wd_valid | input | 1 | Load word strobe from the memory reader |
| wd_data | input | 16 | Load word |
| cam_sel | input | 4 | Entry selected for readback |
| fetch_ptr | output | 16 | Pointer of the descriptor being consumed |
| load_busy | output | 1 | Load in progress |
| load_done | output | 1 | One-cycle pulse when a load completes |
| res_valid | output | 1 | Verdict valid |
| accept | output | 1 | Frame accepted |
| is_mcast | output | 1 | Accepted by the all-multicast rule |
| is_bcast | output | 1 | Accepted by the broadcast rule |
| rb_lo | output | 16 | Readback, bytes 1 and 0 |
| rb_mid | output | 16 | Readback, bytes 3 and 2 |
| rb_hi | output | 16 | Readback, bytes 5 and 4 |

## Verification
The bench targets the precedence corners: the all-ones address with both the multicast and broadcast modes on, a group address under the promiscuous mode alone, and an all-zero address against a zeroed but disabled table. A wrong rule order would raise the broadcast flag or accept the group frame. The load tests check the discarded first word and the byte order within each word. A shifted or swapped slot shows up as a readback mismatch and a failed match. The tests also cover a zero-count load, stray words and a second start during a load. A sequencer that did not gate these would corrupt the table or move `fetch_ptr`.

// File: rtl/cam_filter_pkg.sv
package cam_filter_pkg;

  localparam int ADDR_W          = 48;
  localparam int WORDS_PER_ENTRY = 4;
  localparam int MODE_ALLMC_BIT  = 11;
  localparam int MODE_PROMISC_BIT = 12;
  localparam int MODE_BCAST_BIT  = 13;

  typedef enum logic [1:0] {LD_IDLE, LD_ENTRY, LD_MASK} ld_state_t;

  typedef struct packed {
    logic accept;
    logic mcast;
    logic bcast;
  } verdict_t;

  // Group bit: bit 0 of the first address byte
  function automatic logic addr_is_group(input logic [ADDR_W-1:0] a);
    return a[0];
  endfunction

  function automatic logic addr_is_ones(input logic [ADDR_W-1:0] a);
    return &a;
  endfunction

  // Fixed precedence: promiscuous unicast, all-multicast, broadcast, table
  function automatic verdict_t classify(input logic promisc, input logic allmc,
                                        input logic bc_en, input logic grp,
                                        input logic ones, input logic cam_hit);
    verdict_t v;
    v = '0;
    if (promisc && !grp)     v.accept = 1'b1;
    else if (allmc && grp)   begin v.accept = 1'b1; v.mcast = 1'b1; end
    else if (bc_en && ones)  begin v.accept = 1'b1; v.bcast = 1'b1; end
    else if (cam_hit)        v.accept = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/cam_load_seq.sv
module cam_load_seq
  import cam_filter_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int CNT_W       = 5,
  parameter int PTR_W       = 16,
  parameter int IDX_W       = 4,
  parameter int ENTRY_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic [PTR_W-1:0]  base_in,
  input  logic              wd_valid,
  input  logic [WORD_W-1:0] wd_data,
  output logic              busy,
  output logic              done,
  output logic [PTR_W-1:0]  fetch_ptr,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [1:0]        wr_slot,
  output logic [WORD_W-1:0] wr_data,
  output logic              mask_we,
  output logic [WORD_W-1:0] mask_data
);

  localparam int POS_W = $clog2(WORDS_PER_ENTRY);

  ld_state_t          state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [IDX_W-1:0]   idx_q;
  logic [POS_W-1:0]   pos_q;
  logic [PTR_W-1:0]   ptr_q;
  logic               done_q;
  logic               entry_last_word;

  assign entry_last_word = (state_q == LD_ENTRY) && wd_valid &&
                           (pos_q == POS_W'(WORDS_PER_ENTRY - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LD_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      pos_q   <= '0;
      ptr_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        LD_IDLE: begin
          if (start) begin
            ptr_q   <= base_in;
            cnt_q   <= cnt_in;
            idx_q   <= '0;
            pos_q   <= '0;
            state_q <= (cnt_in != '0) ? LD_ENTRY : LD_MASK;
          end
        end
        LD_ENTRY: begin
          if (wd_valid) begin
            pos_q <= pos_q + 1'b1;
            if (entry_last_word) begin
              cnt_q <= cnt_q - 1'b1;
              ptr_q <= ptr_q + PTR_W'(ENTRY_BYTES);
              idx_q <= idx_q + 1'b1;
              if (cnt_q == CNT_W'(1)) state_q <= LD_MASK;
            end
          end
        end
        LD_MASK: begin
          if (wd_valid) begin
            state_q <= LD_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= LD_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != LD_IDLE);
  assign done      = done_q;
  assign fetch_ptr = ptr_q;
  assign wr_en     = (state_q == LD_ENTRY) && wd_valid && (pos_q != '0);
  assign wr_idx    = idx_q;
  assign wr_slot   = 2'(pos_q - 1'b1);
  assign wr_data   = wd_data;
  assign mask_we   = (state_q == LD_MASK) && wd_valid;
  assign mask_data = wd_data;

endmodule

// File: rtl/cam_store.sv
module cam_store
  import cam_filter_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4,
  parameter int WORD_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [1:0]         wr_slot,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic               mask_we,
  input  logic [ENTRIES-1:0] mask_data,
  input  logic [ADDR_W-1:0]  probe_addr,
  output logic [ENTRIES-1:0] hit_vec,
  input  logic               rd_en,
  input  logic [IDX_W-1:0]   rd_sel,
  output logic [WORD_W-1:0]  rd_lo,
  output logic [WORD_W-1:0]  rd_mid,
  output logic [WORD_W-1:0]  rd_hi
);

  logic [ADDR_W-1:0]  cam_q [ENTRIES];
  logic [ENTRIES-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) cam_q[i] <= '0;
      mask_q <= '0;
    end else begin
      if (wr_en) begin
        case (wr_slot)
          2'd0:    cam_q[wr_idx][15:0]  <= wr_data;
          2'd1:    cam_q[wr_idx][31:16] <= wr_data;
          default: cam_q[wr_idx][47:32] <= wr_data;
        endcase
      end
      if (mask_we) mask_q <= mask_data;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = mask_q[g] && (cam_q[g] == probe_addr);
  end

  assign rd_lo  = rd_en ? cam_q[rd_sel][15:0]  : '0;
  assign rd_mid = rd_en ? cam_q[rd_sel][31:16] : '0;
  assign rd_hi  = rd_en ? cam_q[rd_sel][47:32] : '0;

endmodule

// File: rtl/cam_verdict.sv
module cam_verdict
  import cam_filter_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              probe_valid,
  input  logic [ADDR_W-1:0] probe_addr,
  input  logic              promisc,
  input  logic              allmc,
  input  logic              bc_en,
  input  logic              cam_hit,
  output logic              res_valid,
  output verdict_t          verdict
);

  verdict_t next_v;

  assign next_v = classify(promisc, allmc, bc_en, addr_is_group(probe_addr),
                           addr_is_ones(probe_addr), cam_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      verdict   <= '0;
    end else begin
      res_valid <= probe_valid;
      verdict   <= probe_valid ? next_v : '0;
    end
  end

endmodule

// File: rtl/cam_addr_filter.sv
module cam_addr_filter
  import cam_filter_pkg::*;
#(
  parameter int ENTRIES     = 16,
  parameter int WORD_W      = 16,
  parameter int CNT_W       = 5,
  parameter int PTR_W       = 16,
  parameter int ENTRY_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_reset,
  input  logic [15:0]       rx_ctrl,
  input  logic              dst_valid,
  input  logic [47:0]       dst_addr,
  input  logic              load_start,
  input  logic [CNT_W-1:0]  load_count,
  input  logic [PTR_W-1:0]  load_base,
  input  logic              wd_valid,
  input  logic [WORD_W-1:0] wd_data,
  input  logic [$clog2(ENTRIES)-1:0] cam_sel,
  output logic [PTR_W-1:0]  fetch_ptr,
  output logic              load_busy,
  output logic              load_done,
  output logic              res_valid,
  output logic              accept,
  output logic              is_mcast,
  output logic              is_bcast,
  output logic [WORD_W-1:0] rb_lo,
  output logic [WORD_W-1:0] rb_mid,
  output logic [WORD_W-1:0] rb_hi
);

  localparam int IDX_W = $clog2(ENTRIES);

  logic               wr_en;
  logic [IDX_W-1:0]   wr_idx;
  logic [1:0]         wr_slot;
  logic [WORD_W-1:0]  wr_data;
  logic               mask_we;
  logic [WORD_W-1:0]  mask_word;
  logic [ENTRIES-1:0] hit_vec;
  logic               cam_hit;
  verdict_t           verdict;
  logic               unused_bits;

  assign unused_bits = ^{rx_ctrl[15:14], rx_ctrl[10:0], mask_word};

  cam_load_seq #(
    .WORD_W(WORD_W), .CNT_W(CNT_W), .PTR_W(PTR_W),
    .IDX_W(IDX_W), .ENTRY_BYTES(ENTRY_BYTES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(load_start), .cnt_in(load_count), .base_in(load_base),
    .wd_valid(wd_valid), .wd_data(wd_data),
    .busy(load_busy), .done(load_done), .fetch_ptr(fetch_ptr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_slot(wr_slot), .wr_data(wr_data),
    .mask_we(mask_we), .mask_data(mask_word)
  );

  cam_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_slot(wr_slot), .wr_data(wr_data),
    .mask_we(mask_we), .mask_data(mask_word[ENTRIES-1:0]),
    .probe_addr(dst_addr), .hit_vec(hit_vec),
    .rd_en(in_reset), .rd_sel(cam_sel),
    .rd_lo(rb_lo), .rd_mid(rb_mid), .rd_hi(rb_hi)
  );

  assign cam_hit = |hit_vec;

  cam_verdict u_verdict (
    .clk(clk), .rst_n(rst_n),
    .probe_valid(dst_valid), .probe_addr(dst_addr),
    .promisc(rx_ctrl[MODE_PROMISC_BIT]), .allmc(rx_ctrl[MODE_ALLMC_BIT]),
    .bc_en(rx_ctrl[MODE_BCAST_BIT]), .cam_hit(cam_hit),
    .res_valid(res_valid), .verdict(verdict)
  );

  assign accept   = verdict.accept;
  assign is_mcast = verdict.mcast;
  assign is_bcast = verdict.bcast;

endmodule

// File: rtl/cam_addr_filter_chk.sv
module cam_addr_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_reset,
  input logic [15:0] rx_ctrl,
  input logic        dst_valid,
  input logic [47:0] dst_addr,
  input logic        res_valid,
  input logic        accept,
  input logic        is_mcast,
  input logic        is_bcast,
  input logic        load_busy,
  input logic        load_done,
  input logic [15:0] fetch_ptr,
  input logic [15:0] rb_lo,
  input logic [15:0] rb_mid,
  input logic [15:0] rb_hi,
  input logic        cam_hit
);

  assert_probe_then_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid |=> res_valid);

  assert_result_needs_probe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !accept && !is_mcast && !is_bcast);

  assert_promisc_unicast_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid && rx_ctrl[12] && !dst_addr[0] |=> accept && !is_mcast && !is_bcast);

  assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mcast || is_bcast) |-> accept && !(is_mcast && is_bcast));

  assert_plain_hit_accepts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid && cam_hit |=> accept);

  assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> !load_busy && $past(load_busy));

  assert_idle_ptr_still_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !load_busy |=> load_busy || $stable(fetch_ptr));

  assert_readback_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_reset |-> (rb_lo == 16'h0) && (rb_mid == 16'h0) && (rb_hi == 16'h0));

endmodule

bind cam_addr_filter cam_addr_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_reset(in_reset), .rx_ctrl(rx_ctrl),
  .dst_valid(dst_valid), .dst_addr(dst_addr), .res_valid(res_valid),
  .accept(accept), .is_mcast(is_mcast), .is_bcast(is_bcast),
  .load_busy(load_busy), .load_done(load_done), .fetch_ptr(fetch_ptr),
  .rb_lo(rb_lo), .rb_mid(rb_mid), .rb_hi(rb_hi), .cam_hit(cam_hit)
);

// File: tb/cam_addr_filter_tb.sv
module cam_addr_filter_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_reset = 1'b0;
  logic [15:0] rx_ctrl = '0;
  logic        dst_valid = 1'b0;
  logic [47:0] dst_addr = '0;
  logic        load_start = 1'b0;
  logic [4:0]  load_count = '0;
  logic [15:0] load_base = '0;
  logic        wd_valid = 1'b0;
  logic [15:0] wd_data = '0;
  logic [3:0]  cam_sel = '0;
  logic [15:0] fetch_ptr;
  logic        load_busy, load_done, res_valid, accept, is_mcast, is_bcast;
  logic [15:0] rb_lo, rb_mid, rb_hi;

  int vectors = 0;
  int fails = 0;

  logic [47:0] model_cam [16];
  logic [15:0] model_mask = '0;

  localparam logic [15:0] M_ALLMC = 16'h0800;
  localparam logic [15:0] M_PROM  = 16'h1000;
  localparam logic [15:0] M_BC    = 16'h2000;

  always #2 clk = ~clk;

  cam_addr_filter u_dut (
    .clk(clk), .rst_n(rst_n), .in_reset(in_reset), .rx_ctrl(rx_ctrl),
    .dst_valid(dst_valid), .dst_addr(dst_addr), .load_start(load_start),
    .load_count(load_count), .load_base(load_base), .wd_valid(wd_valid),
    .wd_data(wd_data), .cam_sel(cam_sel), .fetch_ptr(fetch_ptr),
    .load_busy(load_busy), .load_done(load_done), .res_valid(res_valid),
    .accept(accept), .is_mcast(is_mcast), .is_bcast(is_bcast),
    .rb_lo(rb_lo), .rb_mid(rb_mid), .rb_hi(rb_hi)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference verdict {accept, mcast, bcast}, evaluated from the lowest rule up
  function automatic logic [2:0] ref_verdict(input logic [15:0] rc, input logic [47:0] a);
    logic [2:0] r;
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < 16; i++) if (model_mask[i] && model_cam[i] == a) hit = 1'b1;
    r = hit ? 3'b100 : 3'b000;
    if (rc[13] && a == {48{1'b1}}) r = 3'b101;
    if (rc[11] && a[0])            r = 3'b110;
    if (rc[12] && !a[0])           r = 3'b100;
    return r;
  endfunction

  task automatic push_word(input logic [15:0] d);
    wd_valid = 1'b1;
    wd_data  = d;
    @(negedge clk);
    wd_valid = 1'b0;
  endtask

  task automatic start_load(input logic [15:0] base, input logic [4:0] n);
    load_start = 1'b1;
    load_base  = base;
    load_count = n;
    @(negedge clk);
    load_start = 1'b0;
  endtask

  task automatic load_table(input logic [15:0] base, input int n,
                            input logic [15:0] mask, input string tag);
    start_load(base, 5'(n));
    check({tag, " R8 busy after start"}, 64'(load_busy), 64'd1);
    for (int k = 0; k < n; k++) begin
      check({tag, " R8 ptr per entry"}, 64'(fetch_ptr), 64'(base + 16'(8 * k)));
      push_word(16'hBEEF);
      push_word(model_cam[k][15:0]);
      push_word(model_cam[k][31:16]);
      push_word(model_cam[k][47:32]);
    end
    check({tag, " R8 ptr before mask"}, 64'(fetch_ptr), 64'(base + 16'(8 * n)));
    check({tag, " R8 still busy"}, 64'(load_busy), 64'd1);
    push_word(mask);
    model_mask = mask;
    check({tag, " R8 done pulse"}, 64'({load_busy, load_done}), 64'b01);
    @(negedge clk);
    check({tag, " R8 done one cycle"}, 64'(load_done), 64'd0);
  endtask

  task automatic probe(input logic [15:0] rc, input logic [47:0] a, input string tag);
    rx_ctrl   = rc;
    dst_addr  = a;
    dst_valid = 1'b1;
    @(negedge clk);
    dst_valid = 1'b0;
    check({tag, " R2 valid"}, 64'(res_valid), 64'd1);
    check(tag, 64'({accept, is_mcast, is_bcast}), 64'(ref_verdict(rc, a)));
  endtask

  task automatic readback(input int idx, input string tag);
    in_reset = 1'b1;
    cam_sel  = 4'(idx);
    #1;
    check({tag, " R11 readback"}, 64'({rb_hi, rb_mid, rb_lo}), 64'(model_cam[idx]));
    in_reset = 1'b0;
    #1;
    check({tag, " R11 gated"}, 64'({rb_hi, rb_mid, rb_lo}), 64'd0);
  endtask

  task automatic test_reset();
    check("R1 outputs idle", 64'({res_valid, accept, is_mcast, is_bcast, load_busy, load_done}), 64'd0);
    in_reset = 1'b1;
    cam_sel = 4'd5;
    #1;
    check("R1 table zero", 64'({rb_hi, rb_mid, rb_lo}), 64'd0);
    in_reset = 1'b0;
    rx_ctrl = '0;
    dst_addr = '0;
    dst_valid = 1'b1;
    @(negedge clk);
    dst_valid = 1'b0;
    check("R1 zero addr rejected by empty mask", 64'({res_valid, accept}), 64'b10);
    @(negedge clk);
    check("R2 no probe no result", 64'({res_valid, accept}), 64'd0);
  endtask

  task automatic test_load_and_match();
    model_cam[0] = 48'h665544332210;
    model_cam[1] = 48'h0B0A09080706;
    model_cam[2] = 48'hCCBBAA998802;
    load_table(16'h1000, 3, 16'h0005, "R7 load3");
    readback(0, "R7 entry0");
    readback(2, "R7 entry2");
    probe(16'h0000, model_cam[0], "R6 enabled entry hit");
    check("R6 explicit accept", 64'(accept), 64'd1);
    probe(16'h0000, model_cam[1], "R6 disabled entry");
    check("R6 explicit reject", 64'(accept), 64'd0);
    probe(16'h0000, 48'h123456789A00, "R6 no match");
    probe(16'h0000, model_cam[2], "R6 entry2 hit");
    probe(16'h00FF, model_cam[2], "R6 low ctrl bits inert");
  endtask

  task automatic test_modes();
    probe(M_PROM, 48'h0000DEAD0042, "R3 promisc unicast");
    check("R3 explicit", 64'({accept, is_mcast, is_bcast}), 64'b100);
    probe(M_PROM, 48'h0000DEAD0043, "R3 promisc group not taken");
    check("R3 group rejected", 64'(accept), 64'd0);
    probe(M_ALLMC, 48'h00000000005E01, "R4 group accepted mc");
    check("R4 explicit", 64'({accept, is_mcast, is_bcast}), 64'b110);
    probe(M_ALLMC | M_BC, {48{1'b1}}, "R4 mc beats bc");
    check("R4 ones gets mc", 64'({is_mcast, is_bcast}), 64'b10);
    probe(M_BC, {48{1'b1}}, "R5 broadcast");
    check("R5 explicit", 64'({accept, is_mcast, is_bcast}), 64'b101);
    probe(16'h0000, {48{1'b1}}, "R5 bc off rejects");
    probe(M_BC, 48'h0000000000F1, "R5 other group under bc");
  endtask

  task automatic test_zero_count();
    start_load(16'h2000, 5'd0);
    check("R9 busy", 64'(load_busy), 64'd1);
    check("R9 ptr", 64'(fetch_ptr), 64'h2000);
    push_word(16'h0002);
    model_mask = 16'h0002;
    check("R9 done after one word", 64'({load_busy, load_done}), 64'b01);
    probe(16'h0000, model_cam[1], "R9 entry1 now enabled");
    probe(16'h0000, model_cam[0], "R9 entry0 now disabled");
    readback(1, "R9 table kept");
  endtask

  task automatic test_ignored();
    push_word(16'h5555);
    push_word(16'hAAAA);
    check("R10 stray words no busy", 64'({load_busy, load_done}), 64'd0);
    check("R10 ptr unmoved", 64'(fetch_ptr), 64'h2000);
    readback(0, "R10 entry0 intact");
    readback(1, "R10 entry1 intact");
    model_cam[0] = 48'h1F1E1D1C1B1A;
    start_load(16'h3000, 5'd1);
    push_word(16'h0001);
    push_word(model_cam[0][15:0]);
    load_start = 1'b1;
    load_base  = 16'h4000;
    load_count = 5'd5;
    @(negedge clk);
    load_start = 1'b0;
    check("R10 restart ignored ptr", 64'(fetch_ptr), 64'h3000);
    push_word(model_cam[0][31:16]);
    push_word(model_cam[0][47:32]);
    check("R10 count kept, in mask phase", 64'(fetch_ptr), 64'h3008);
    push_word(16'h0001);
    model_mask = 16'h0001;
    check("R10 done on original count", 64'({load_busy, load_done}), 64'b01);
    readback(0, "R10 reloaded entry0");
    probe(16'h0000, model_cam[0], "R10 new entry matches");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model_cam[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_load_and_match();
    test_modes();
    test_zero_count();
    test_ignored();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule